// File: doc/BRIEF.md
# Dual-Bank Colour Matrix Transform

This block transforms an RGB pixel stream with a 3x4 colour matrix. Each output channel is a weighted sum of the three input channels plus a per-row offset. The result is rounded and clamped to the unsigned pixel range. Pixels enter and leave through a valid/data interface with a fixed pipeline delay.

The block holds two complete coefficient sets, set A and set B, of twelve coefficients each. A small register write port loads them, with two coefficients packed into each register. A mode register requests bypass, set A or set B. The request is held pending and becomes the applied mode only on a frame-start strobe. The applied mode is always visible on an output. Software reads the applied mode, loads the bank that is not in use, requests it, and lets the next frame start switch over cleanly.

Top module: `ccm_dualbank`

## Requirements
- R1: While reset is asserted and right after it, the applied mode reads 0 (bypass) and `outValid` is low; all coefficients are zero.
- R2: A write to address 0x10 stores `cfgWdata[1:0]` as the pending mode. `curMode` takes the pending value only on a clock edge where `frameStart` is high. A mode write in the same cycle as `frameStart` becomes applied at the following frame start.
- R3: Applied mode 0 (bypass), and also the reserved mode 3, pass the pixel through unchanged whatever the stored coefficients are.
- R4: Applied mode 1 uses set A and applied mode 2 uses set B. With coefficient Crc (row r, column c) as signed fixed point with 10 fraction bits, output channel r = (Cr1*R + Cr2*G + Cr3*B)/1024 + Cr4. Cr4 is a signed integer offset in pixel units. Pixels pack R in bits [9:0], G in [19:10] and B in [29:20].
- R5: The fractional result rounds half up, to floor(x + 0.5).
- R6: A result below 0 gives 0, and a result above 1023 gives 1023.
- R7: Coefficient addresses have bit 4 clear. Bit 3 selects the bank (0 = A, 1 = B). Bits [2:0] hold a pair index p from 0 to 5, which writes coefficient 2p from `cfgWdata[11:0]` and coefficient 2p+1 from `cfgWdata[23:12]`. The coefficients are numbered C11, C12, C13, C14, C21 … C34 from 0. Pair indices 6 and 7, and any address with bit 4 set other than 0x10, change nothing.
- R8: A pixel sampled on edge k appears on `outPix` after edge k+2, three cycles of latency. `outValid` is `inValid` delayed by the same three edges.
- R9: A pixel uses the applied mode and coefficients as they stood before its sampling edge. A coefficient write therefore affects pixels sampled from the next edge on, whichever bank is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 5 | Register address |
| cfgWdata | input | 24 | Register write data (two coefficients or a mode) |
| frameStart | input | 1 | Frame-start strobe; applies the pending mode |
| curMode | output | 2 | Applied mode (0 bypass, 1 set A, 2 set B, 3 bypass) |
| inValid | input | 1 | Input pixel valid |
| inPix | input | 30 | Input pixel {B, G, R} |
| outValid | output | 1 | Output pixel valid |
| outPix | output | 30 | Output pixel {B, G, R} |

## Verification
Every output pixel is due exactly three edges after the edge that sampled its input, and `curMode` is due on the edge that sampled `frameStart`. A coefficient or mode write is seen by pixels sampled on the edge after it. The bench keeps a behavioural model that evaluates each pixel at its sampling edge, using the state from before that edge. It queues the result and compares the entry three edges old against the ports at every falling edge. Directed cases drive a pixel, wait three edges and compare hand-computed values for rounding, clamping, packing and same-cycle collisions of writes with pixels or frame starts.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SET_A  = 2'd1,
    MODE_SET_B  = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  // strobes from control to datapath, valid in the pixel's sampling cycle
  typedef struct packed {
    logic passThru;
    logic bankB;
  } dpCtrl_t;

  localparam int NUM_ROWS = 3;
  localparam int NUM_COLS = 4;
  localparam int NUM_COEF = NUM_ROWS * NUM_COLS;

endpackage

// File: rtl/ccm_ctrl.sv
module ccm_ctrl
  import ccm_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] MODE_ADDR = {1'b1, {(ADDR_W-1){1'b0}}},
  localparam int DATA_W = 2 * COEF_W,
  localparam int BANK_W = NUM_COEF * COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              frameStart,
  output logic [1:0]        curMode,
  output dpCtrl_t           dpCtrl,
  output logic [BANK_W-1:0] coefA,
  output logic [BANK_W-1:0] coefB
);

  localparam int NUM_PAIR = NUM_COEF / 2;

  mode_e reqQ, curQ;
  logic [COEF_W-1:0] bankQ [2][NUM_COEF];

  logic       modeHit;
  logic       coefHit;
  logic       bankIdx;
  logic [2:0] pairIdx;

  assign modeHit = cfgWe && (cfgAddr == MODE_ADDR);
  assign coefHit = cfgWe && (cfgAddr[ADDR_W-1:4] == '0);
  assign bankIdx = cfgAddr[3];
  assign pairIdx = cfgAddr[2:0];

  // pending and applied mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= MODE_BYPASS;
      curQ <= MODE_BYPASS;
    end else begin
      if (modeHit)    reqQ <= mode_e'(cfgWdata[1:0]);
      if (frameStart) curQ <= reqQ;
    end
  end

  // coefficient banks, two coefficients per write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_COEF; i++)
          bankQ[b][i] <= '0;
    end else if (coefHit) begin
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < NUM_PAIR; p++)
          if ((int'(bankIdx) == b) && (int'(pairIdx) == p)) begin
            bankQ[b][2*p]   <= cfgWdata[COEF_W-1:0];
            bankQ[b][2*p+1] <= cfgWdata[DATA_W-1:COEF_W];
          end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_COEF; i++) begin
      coefA[i*COEF_W +: COEF_W] = bankQ[0][i];
      coefB[i*COEF_W +: COEF_W] = bankQ[1][i];
    end
  end

  assign dpCtrl.passThru = (curQ == MODE_BYPASS) || (curQ == MODE_RSVD);
  assign dpCtrl.bankB    = (curQ == MODE_SET_B);
  assign curMode         = curQ;

endmodule

// File: rtl/ccm_datapath.sv
module ccm_datapath
  import ccm_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 12,
  parameter int FRAC_W = 10,
  localparam int BANK_W = NUM_COEF * COEF_W,
  localparam int BUS_W  = NUM_ROWS * PIX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [BANK_W-1:0] coefA,
  input  logic [BANK_W-1:0] coefB,
  input  logic              inValid,
  input  logic [BUS_W-1:0]  inPix,
  output logic              outValid,
  output logic [BUS_W-1:0]  outPix
);

  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int SHL_W  = COEF_W + FRAC_W;
  localparam int ACC_W  = ((PROD_W > SHL_W) ? PROD_W : SHL_W) + 3;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;
  localparam logic [ACC_W-1:0] ROUND_K = ACC_W'(1) << (FRAC_W - 1);

  function automatic logic [PROD_W-1:0] mulSU(input logic [COEF_W-1:0] c,
                                              input logic [PIX_W-1:0]  p);
    logic [PROD_W-1:0] cx, px;
    cx = {{(PROD_W-COEF_W){c[COEF_W-1]}}, c};
    px = {{(PROD_W-PIX_W){1'b0}}, p};
    return cx * px;
  endfunction

  function automatic logic [ACC_W-1:0] sxProd(input logic [PROD_W-1:0] x);
    return {{(ACC_W-PROD_W){x[PROD_W-1]}}, x};
  endfunction

  logic [BANK_W-1:0] coefSel;
  assign coefSel = dpCtrl.bankB ? coefB : coefA;

  logic             v1, v2, v3;
  logic             byp1, byp2;
  logic [BUS_W-1:0] pix1, pix2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      byp1 <= 1'b0; byp2 <= 1'b0;
      pix1 <= '0; pix2 <= '0;
    end else begin
      v1   <= inValid;
      v2   <= v1;
      v3   <= v2;
      byp1 <= dpCtrl.passThru;
      byp2 <= byp1;
      pix1 <= inPix;
      pix2 <= pix1;
    end
  end

  assign outValid = v3;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [PROD_W-1:0] prodD [NUM_ROWS];
    logic [PROD_W-1:0] prodQ [NUM_ROWS];
    logic [COEF_W-1:0] offQ;
    logic [ACC_W-1:0]  accD, accQ, shD;
    logic [PIX_W-1:0]  clampD, resQ;

    // stage 1: three products and the offset
    always_comb begin
      for (int c = 0; c < NUM_ROWS; c++)
        prodD[c] = mulSU(coefSel[(r*NUM_COLS+c)*COEF_W +: COEF_W],
                         inPix[c*PIX_W +: PIX_W]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int c = 0; c < NUM_ROWS; c++) prodQ[c] <= '0;
        offQ <= '0;
      end else begin
        for (int c = 0; c < NUM_ROWS; c++) prodQ[c] <= prodD[c];
        offQ <= coefSel[(r*NUM_COLS+NUM_COLS-1)*COEF_W +: COEF_W];
      end
    end

    // stage 2: sum with scaled offset and rounding constant
    always_comb begin
      accD = sxProd(prodQ[0]) + sxProd(prodQ[1]) + sxProd(prodQ[2])
           + {{(ACC_W-SHL_W){offQ[COEF_W-1]}}, offQ, {FRAC_W{1'b0}}}
           + ROUND_K;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accQ <= '0;
      else       accQ <= accD;
    end

    // stage 3: drop fraction, clamp, choose bypass
    assign shD = $signed(accQ) >>> FRAC_W;

    always_comb begin
      if (shD[ACC_W-1])                clampD = '0;
      else if (|shD[ACC_W-2:PIX_W])    clampD = PIX_MAX;
      else                             clampD = shD[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resQ <= '0;
      else       resQ <= byp2 ? pix2[r*PIX_W +: PIX_W] : clampD;
    end

    assign outPix[r*PIX_W +: PIX_W] = resQ;
  end

endmodule

// File: rtl/ccm_dualbank.sv
module ccm_dualbank
  import ccm_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 12,
  parameter int FRAC_W = 10,
  parameter int ADDR_W = 5,
  localparam int DATA_W = 2 * COEF_W,
  localparam int BUS_W  = NUM_ROWS * PIX_W,
  localparam int BANK_W = NUM_COEF * COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              frameStart,
  output logic [1:0]        curMode,
  input  logic              inValid,
  input  logic [BUS_W-1:0]  inPix,
  output logic              outValid,
  output logic [BUS_W-1:0]  outPix
);

  dpCtrl_t           dpCtrl;
  logic [BANK_W-1:0] coefA, coefB;

  ccm_ctrl #(
    .COEF_W(COEF_W),
    .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .frameStart(frameStart),
    .curMode   (curMode),
    .dpCtrl    (dpCtrl),
    .coefA     (coefA),
    .coefB     (coefB)
  );

  ccm_datapath #(
    .PIX_W (PIX_W),
    .COEF_W(COEF_W),
    .FRAC_W(FRAC_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .coefA   (coefA),
    .coefB   (coefB),
    .inValid (inValid),
    .inPix   (inPix),
    .outValid(outValid),
    .outPix  (outPix)
  );

endmodule

// File: rtl/ccm_dualbank_chk.sv
module ccm_dualbank_chk #(
  parameter int PIX_W = 10,
  localparam int BUS_W = 3 * PIX_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStart,
  input logic [1:0]       curMode,
  input logic             inValid,
  input logic [BUS_W-1:0] inPix,
  input logic             outValid,
  input logic [BUS_W-1:0] outPix
);

  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cyc <= 2'd0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (curMode == 2'd0 && !outValid));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0 && !$past(frameStart)) |-> $stable(curMode));

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && $past(inValid, 3) &&
     ($past(curMode, 3) == 2'd0 || $past(curMode, 3) == 2'd3))
    |-> outPix == $past(inPix, 3));

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3) |-> outValid == $past(inValid, 3));

endmodule

bind ccm_dualbank ccm_dualbank_chk #(.PIX_W(PIX_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .frameStart(frameStart),
  .curMode   (curMode),
  .inValid   (inValid),
  .inPix     (inPix),
  .outValid  (outValid),
  .outPix    (outPix)
);

// File: tb/ccm_dualbank_tb.sv
`timescale 1ns/1ps
module ccm_dualbank_tb_top;

  localparam int PW = 10;
  localparam int CW = 12;
  localparam int PMAX = (1 << PW) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [23:0] cfgWdata = '0;
  logic        frameStart = 1'b0;
  logic [1:0]  curMode;
  logic        inValid = 1'b0;
  logic [29:0] inPix = '0;
  logic        outValid;
  logic [29:0] outPix;

  always #2.5 clk = ~clk;

  ccm_dualbank dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .frameStart(frameStart), .curMode(curMode),
    .inValid(inValid), .inPix(inPix), .outValid(outValid), .outPix(outPix)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { bit v; int r; int g; int b; } ent_t;
  ent_t q[$];
  int coefM [2][12];
  int pendM = 0;
  int curM = 0;

  function automatic int sx(input int v);
    return (v >= (1 << (CW-1))) ? v - (1 << CW) : v;
  endfunction

  function automatic int chan(input int bk, input int row, input int pr,
                              input int pg, input int pb);
    int s;
    s = coefM[bk][row*4] * pr + coefM[bk][row*4+1] * pg +
        coefM[bk][row*4+2] * pb + coefM[bk][row*4+3] * 1024 + 512;
    s = s >>> 10;
    if (s < 0) s = 0;
    if (s > PMAX) s = PMAX;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      for (int b = 0; b < 2; b++) for (int i = 0; i < 12; i++) coefM[b][i] = 0;
      pendM = 0;
      curM = 0;
    end else begin
      ent_t e;
      int pr, pg, pb;
      pr = int'(inPix[9:0]); pg = int'(inPix[19:10]); pb = int'(inPix[29:20]);
      e.v = inValid;
      if (curM == 0 || curM == 3) begin
        e.r = pr; e.g = pg; e.b = pb;
      end else begin
        e.r = chan(curM - 1, 0, pr, pg, pb);
        e.g = chan(curM - 1, 1, pr, pg, pb);
        e.b = chan(curM - 1, 2, pr, pg, pb);
      end
      q.push_back(e);
      if (q.size() > 3) void'(q.pop_front());
      if (frameStart) curM = pendM;
      if (cfgWe) begin
        if (cfgAddr == 5'h10) pendM = int'(cfgWdata[1:0]);
        else if (!cfgAddr[4] && cfgAddr[2:0] < 3'd6) begin
          coefM[cfgAddr[3]][2*cfgAddr[2:0]]   = sx(int'(cfgWdata[11:0]));
          coefM[cfgAddr[3]][2*cfgAddr[2:0]+1] = sx(int'(cfgWdata[23:12]));
        end
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit ev;
      ev = (q.size() == 3) ? q[0].v : 1'b0;
      chk(outValid == ev, tag, "outValid", int'(outValid), int'(ev));
      chk(int'(curMode) == curM, tag, "curMode", int'(curMode), curM);
      if (ev) begin
        chk(int'(outPix[9:0])   == q[0].r, tag, "R chan", int'(outPix[9:0]), q[0].r);
        chk(int'(outPix[19:10]) == q[0].g, tag, "G chan", int'(outPix[19:10]), q[0].g);
        chk(int'(outPix[29:20]) == q[0].b, tag, "B chan", int'(outPix[29:20]), q[0].b);
      end
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wrReg(input logic [4:0] a, input logic [23:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic wrPair(input int bk, input int p, input int lo, input int hi);
    wrReg(5'(bk * 8 + p), {12'(hi), 12'(lo)});
  endtask

  task automatic loadBank(input int bk, input int m[12]);
    for (int p = 0; p < 6; p++) wrPair(bk, p, m[2*p], m[2*p+1]);
  endtask

  task automatic frame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic pixCheck(input string t, input int r, input int g, input int b,
                          input int er, input int eg, input int eb);
    inValid = 1'b1; inPix = {10'(b), 10'(g), 10'(r)};
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(outValid == 1'b1, t, "direct valid", int'(outValid), 1);
    chk(int'(outPix[9:0])   == er, t, "direct R", int'(outPix[9:0]), er);
    chk(int'(outPix[19:10]) == eg, t, "direct G", int'(outPix[19:10]), eg);
    chk(int'(outPix[29:20]) == eb, t, "direct B", int'(outPix[29:20]), eb);
  endtask

  int ident[12] = '{1024,0,0,0, 0,1024,0,0, 0,0,1024,0};
  int swapM[12] = '{0,1024,0,0, 0,0,1024,0, 1024,0,0,0};

  initial begin
    #1 rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(curMode == 2'd0, "R1", "curMode in reset", int'(curMode), 0);
    chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(curMode == 2'd0, "R1", "curMode after reset", int'(curMode), 0);

    // R3: bypass ignores loaded coefficients
    tag = "R3";
    loadBank(0, swapM);
    loadBank(1, swapM);
    pixCheck("R3", 11, 22, 33, 11, 22, 33);

    // R2: pending mode applied only at frame start
    tag = "R2";
    wrReg(5'h10, 24'd1);
    chk(curMode == 2'd0, "R2", "held before frame", int'(curMode), 0);
    pixCheck("R2", 5, 6, 7, 5, 6, 7);
    frame();
    chk(curMode == 2'd1, "R2", "after frame", int'(curMode), 1);
    cfgWe = 1'b1; cfgAddr = 5'h10; cfgWdata = 24'd2; frameStart = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; frameStart = 1'b0;
    chk(curMode == 2'd1, "R2", "same-cycle write not yet applied", int'(curMode), 1);
    frame();
    chk(curMode == 2'd2, "R2", "applied next frame", int'(curMode), 2);

    // R4: set B swap, set A identity with offset
    tag = "R4";
    pixCheck("R4", 100, 200, 300, 200, 300, 100);
    loadBank(0, ident);
    wrPair(0, 1, 0, 5);
    wrReg(5'h10, 24'd1);
    frame();
    pixCheck("R4", 10, 20, 30, 15, 20, 30);

    // R7: packing and ignored addresses
    tag = "R7";
    wrPair(0, 1, 0, 7);
    pixCheck("R7", 10, 20, 30, 17, 20, 30);
    wrReg(5'h06, 24'hFFFFFF);
    wrReg(5'h07, 24'hABCDEF);
    wrReg(5'h11, 24'h000002);
    wrReg(5'h1F, 24'h123456);
    loadBank(1, ident);
    pixCheck("R7", 10, 20, 30, 17, 20, 30);
    chk(curMode == 2'd1, "R7", "mode after ignored writes", int'(curMode), 1);

    // R5: round half up through set B
    tag = "R5";
    wrPair(1, 0, 512, 0);
    wrReg(5'h10, 24'd2);
    frame();
    pixCheck("R5", 3, 40, 50, 2, 40, 50);
    pixCheck("R5", 5, 40, 50, 3, 40, 50);
    pixCheck("R5", 1, 40, 50, 1, 40, 50);

    // R6: clamp both ends
    tag = "R6";
    wrPair(1, 0, 2047, 0);
    pixCheck("R6", 1000, 1, 2, 1023, 1, 2);
    wrPair(1, 0, 2048, 0);
    pixCheck("R6", 100, 1, 2, 0, 1, 2);
    wrPair(1, 0, 1024, 0);
    wrPair(1, 1, 0, 4093);
    pixCheck("R6", 1, 1, 2, 0, 1, 2);
    wrPair(1, 1, 0, 0);

    // R9: write colliding with a pixel
    tag = "R9";
    cfgWe = 1'b1; cfgAddr = 5'h08; cfgWdata = 24'd0;
    inValid = 1'b1; inPix = {10'd3, 10'd2, 10'd100};
    @(negedge clk);
    cfgWe = 1'b0;
    inPix = {10'd3, 10'd2, 10'd100};
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk(int'(outPix[9:0]) == 100, "R9", "old coefficient", int'(outPix[9:0]), 100);
    @(negedge clk);
    chk(int'(outPix[9:0]) == 0, "R9", "new coefficient", int'(outPix[9:0]), 0);
    wrPair(1, 0, 1024, 0);

    // R3: reserved mode 3 bypasses
    tag = "R3";
    wrReg(5'h10, 24'd3);
    frame();
    pixCheck("R3", 9, 8, 7, 9, 8, 7);

    // R8: back-to-back and gapped streams
    tag = "R8";
    wrReg(5'h10, 24'd1);
    frame();
    for (int i = 0; i < 40; i++) begin
      inValid = (i % 5) != 4;
      inPix = 30'($urandom);
      @(negedge clk);
    end
    inValid = 1'b0;

    // R4: random mixed traffic checked by the model
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      inValid = ($urandom_range(0, 3) != 0);
      inPix = 30'($urandom);
      frameStart = ($urandom_range(0, 19) == 0);
      cfgWe = ($urandom_range(0, 5) == 0);
      cfgAddr = ($urandom_range(0, 7) == 0) ? 5'h10 : 5'($urandom);
      cfgWdata = 24'($urandom);
      @(negedge clk);
    end
    inValid = 1'b0; frameStart = 1'b0; cfgWe = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL %s watchdog expired actual=%0d expected=%0d", tag, 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule